// File: doc/BRIEF.md
# Fractional and Half-Step Clock Divider

This block turns one of several source enable streams into a divided clock level. All sources live in a single clock domain that runs at twice the nominal source rate. Each asserted source enable is one source half-period, or tick. A three-bit source code picks the stream. A pre-divider that counts ticks then divides the source rate by (hid+1)/2, which makes half-integer ratios possible. An optional fractional stage can follow. It steps an accumulator by M once per pre-divided period and wraps it at N, so the output makes M periods for every N pre-divided periods. The high time of the output is set by a separate threshold D.

The fractional parameters use inverted encodings. The N field holds the bitwise inverse of (N - M), so the effective N is recovered as the inverse of the field plus M. The D field holds the bitwise inverse of the threshold, so a field equal to the inverse of N gives a half-duty output. A live configuration is captured into a shadow copy, and that copy is replaced only when an output period ends, so no pulse is ever cut short. When the root enable is low, the output is forced low, the running flag clears and every counter returns to its start.

Top module: `frac_clk_div`

## Requirements
- R1: During reset, `clk_out` and `running` are both 0.
- R2: `cfg_sel` values below NUM_SRC select `src_en[cfg_sel]`. Any code from NUM_SRC up to 7 selects `src_en[0]`.
- R3: When the fractional stage is bypassed, the output period is 2 ticks for `cfg_hid` values 0 and 1, and `cfg_hid`+1 ticks for larger values.
- R4: In each pre-divided period of P ticks, the output is high for the first ceil(P/2) ticks and low for the remaining floor(P/2) ticks. An odd P therefore gives high and low phases that differ by exactly one tick.
- R5: The effective N is (~`cfg_n_inv`)+M, computed one bit wider than MND_W, and the threshold D is ~`cfg_d_inv`. In fractional mode the accumulator steps by M at the end of each pre-divided period, wraps at N, and always stays below N. The output is high while 2*accumulator < D.
- R6: Fractional mode is active only when `cfg_dual` is 1, N is nonzero and M differs from N. In every other case the output follows the pre-divider.
- R7: A configuration change takes effect only where an output period ends, meaning a pre-divider end in bypass mode or an accumulator wrap in fractional mode. The period already in progress completes with the old settings, and the new period starts from a zero count.
- R8: One cycle after `root_en` is sampled low, `clk_out` and `running` are both 0. One cycle after `root_en` is sampled high, `running` is 1. Re-enabling starts from the live configuration with the counters cleared.
- R9: While the selected source gives no tick and `root_en` stays high, `clk_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at twice the source rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_en | input | 1 | Root enable; low forces the output off |
| src_en | input | NUM_SRC | Per-source tick enables |
| cfg_sel | input | 3 | Source select code |
| cfg_hid | input | HID_W | Half-step pre-divide field |
| cfg_dual | input | 1 | Requests the fractional (dual-edge) mode |
| cfg_m | input | MND_W | Fractional numerator M |
| cfg_n_inv | input | MND_W | Inverse of (N - M) |
| cfg_d_inv | input | MND_W | Inverse of the high-time threshold D |
| clk_out | output | 1 | Divided clock level |
| running | output | 1 | Set while the root is enabled |

## Verification
The hardest behaviour to reach is a configuration change that arrives partway through a long output period. To show that the change is held back, the check has to see the old high and low phase lengths complete in full before the new ones appear. The stimulus waits for a rising output edge during a nine-tick period, changes the pre-divide field on that exact sample, and then measures four consecutive run lengths. Random phases also change the live configuration without pausing the root, under sparse random source ticks. Those changes therefore land at arbitrary points in a period, and they are checked cycle by cycle against a reference model in the bench.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned SEL_CODES = 1 << SEL_W;

   typedef enum logic [1:0] {
      PATH_IDLE  = 2'd0,
      PATH_PLAIN = 2'd1,
      PATH_FRAC  = 2'd2
   } path_e;
endpackage

// File: rtl/fcd_src_mux.sv
module fcd_src_mux
   import frac_clk_div_pkg::*;
#(
   parameter int unsigned NUM_SRC = 5
) (
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   logic [SEL_CODES-1:0] lane;

   // Codes without a real source are wired to lane 0.
   generate
      for (genvar g = 0; g < SEL_CODES; g++) begin : g_lane
         if (g < NUM_SRC) begin : g_real
            assign lane[g] = src_en[g];
         end else begin : g_fallback
            assign lane[g] = src_en[0];
         end
      end
   endgenerate

   assign tick = lane[sel];
endmodule

// File: rtl/fcd_half_div.sv
module fcd_half_div #(
   parameter int unsigned HID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [HID_W-1:0] hid,
   output logic             last_tick,
   output logic             level
);
   localparam int unsigned CW = HID_W + 1;

   logic [CW-1:0] period;
   logic [CW-1:0] cnt;
   logic          at_last;

   // Ticks per pre-divided period: 2 when bypassed, else hid+1.
   always_comb begin
      if (hid <= HID_W'(1)) period = CW'(2);
      else                  period = CW'(hid) + CW'(1);
   end

   assign at_last   = (cnt == period - CW'(1));
   assign last_tick = tick && at_last;
   assign level     = ({cnt, 1'b0} < {1'b0, period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= at_last ? '0 : cnt + CW'(1);
   end
endmodule

// File: rtl/fcd_mn_accum.sv
module fcd_mn_accum #(
   parameter int unsigned MND_W  = 8,
   parameter int unsigned HAS_MN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             active,
   input  logic [MND_W-1:0] m,
   input  logic [MND_W:0]   n_eff,
   input  logic [MND_W-1:0] d_val,
   output logic             wrap,
   output logic             level,
   output logic [MND_W:0]   acc_o
);
   localparam int unsigned AW = MND_W + 1;

   generate
      if (HAS_MN != 0) begin : g_frac
         logic [AW-1:0] acc;
         logic [AW:0]   sum;

         assign sum   = {1'b0, acc} + {2'b00, m};
         assign wrap  = (sum >= {1'b0, n_eff});
         assign level = ({acc, 1'b0} < {2'b00, d_val});
         assign acc_o = acc;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                acc <= '0;
            else if (clr)              acc <= '0;
            else if (step && active)   acc <= wrap ? AW'(sum - {1'b0, n_eff}) : AW'(sum);
         end
      end else begin : g_none
         assign wrap  = 1'b1;
         assign level = 1'b0;
         assign acc_o = '0;
      end
   endgenerate
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import frac_clk_div_pkg::*;
#(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned HID_W   = 5,
   parameter int unsigned MND_W   = 8,
   parameter int unsigned HAS_MN  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               root_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [2:0]         cfg_sel,
   input  logic [HID_W-1:0]   cfg_hid,
   input  logic               cfg_dual,
   input  logic [MND_W-1:0]   cfg_m,
   input  logic [MND_W-1:0]   cfg_n_inv,
   input  logic [MND_W-1:0]   cfg_d_inv,
   output logic               clk_out,
   output logic               running
);
   localparam int unsigned CFG_W = SEL_W + HID_W + 1 + 3 * MND_W;
   localparam bit          MN_ON = (HAS_MN != 0);

   generate
      if (HID_W < 2) begin : g_bad_hid
         $error("frac_clk_div: HID_W must be at least 2");
      end
      if (MND_W < 2) begin : g_bad_mnd
         $error("frac_clk_div: MND_W must be at least 2");
      end
      if (NUM_SRC < 1 || NUM_SRC > SEL_CODES) begin : g_bad_src
         $error("frac_clk_div: NUM_SRC out of range");
      end
   endgenerate

   logic [CFG_W-1:0] live_vec;
   logic [CFG_W-1:0] shadow_vec;
   logic [SEL_W-1:0] sh_sel;
   logic [HID_W-1:0] sh_hid;
   logic             sh_dual;
   logic [MND_W-1:0] sh_m;
   logic [MND_W-1:0] sh_n_inv;
   logic [MND_W-1:0] sh_d_inv;

   assign live_vec = {cfg_sel, cfg_hid, cfg_dual, cfg_m, cfg_n_inv, cfg_d_inv};
   assign {sh_sel, sh_hid, sh_dual, sh_m, sh_n_inv, sh_d_inv} = shadow_vec;

   // Decoding of the inverted N and D fields.
   logic [MND_W:0]   n_eff;
   logic [MND_W-1:0] d_val;
   logic             frac_on;

   assign n_eff   = {1'b0, ~sh_n_inv} + {1'b0, sh_m};
   assign d_val   = ~sh_d_inv;
   assign frac_on = MN_ON && sh_dual && (n_eff != '0) && ({1'b0, sh_m} != n_eff);

   logic tick_sel;
   logic tick;
   logic pd_end;
   logic pd_level;
   logic mn_wrap;
   logic mn_level;
   logic [MND_W:0] mn_acc;
   logic boundary;
   logic reload;
   logic div_clr;

   fcd_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .src_en (src_en),
      .sel    (sh_sel),
      .tick   (tick_sel)
   );

   assign tick = tick_sel && root_en;

   fcd_half_div #(.HID_W(HID_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (div_clr),
      .tick      (tick),
      .hid       (sh_hid),
      .last_tick (pd_end),
      .level     (pd_level)
   );

   fcd_mn_accum #(.MND_W(MND_W), .HAS_MN(HAS_MN)) u_mn (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (div_clr),
      .step   (pd_end),
      .active (frac_on),
      .m      (sh_m),
      .n_eff  (n_eff),
      .d_val  (d_val),
      .wrap   (mn_wrap),
      .level  (mn_level),
      .acc_o  (mn_acc)
   );

   // An output period ends on a pre-divider end, gated by wrap in frac mode.
   assign boundary = pd_end && (frac_on ? mn_wrap : 1'b1);
   assign reload   = boundary && (live_vec != shadow_vec);
   assign div_clr  = !root_en || reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  shadow_vec <= '0;
      else if (!root_en || reload) shadow_vec <= live_vec;
   end

   path_e path;
   always_comb begin
      if (!root_en)     path = PATH_IDLE;
      else if (frac_on) path = PATH_FRAC;
      else              path = PATH_PLAIN;
   end

   logic out_q;
   logic run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         run_q <= 1'b0;
      end else begin
         run_q <= root_en;
         unique case (path)
            PATH_FRAC:  out_q <= mn_level;
            PATH_PLAIN: out_q <= pd_level;
            default:    out_q <= 1'b0;
         endcase
      end
   end

   assign clk_out = out_q;
   assign running = run_q;
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned CFG_W   = 36,
   parameter int unsigned MND_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             root_en,
   input logic             tick_sel,
   input logic             src0,
   input logic             pd_end,
   input logic             clk_out,
   input logic             running,
   input logic             frac_on,
   input logic [2:0]       sel,
   input logic [CFG_W-1:0] shadow_vec,
   input logic [MND_W:0]   acc,
   input logic [MND_W:0]   n_eff
);
   assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !root_en |=> (!clk_out && !running));

   assert_on_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      root_en |=> running);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (root_en && !tick_sel) ##1 root_en |=> $stable(clk_out));

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (root_en && !pd_end) |=> $stable(shadow_vec));

   assert_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel} >= 4'(NUM_SRC)) |-> (tick_sel == src0));

   assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frac_on |-> (acc < n_eff));
endmodule

bind frac_clk_div frac_clk_div_chk #(
   .NUM_SRC (NUM_SRC),
   .CFG_W   (CFG_W),
   .MND_W   (MND_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .root_en    (root_en),
   .tick_sel   (tick_sel),
   .src0       (src_en[0]),
   .pd_end     (pd_end),
   .clk_out    (clk_out),
   .running    (running),
   .frac_on    (frac_on),
   .sel        (sh_sel),
   .shadow_vec (shadow_vec),
   .acc        (mn_acc),
   .n_eff      (n_eff)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
   localparam int NSRC = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            root_en = 1'b0;
   logic [NSRC-1:0] src_en = '0;
   logic [2:0]      cfg_sel = '0;
   logic [4:0]      cfg_hid = '0;
   logic            cfg_dual = 1'b0;
   logic [7:0]      cfg_m = '0;
   logic [7:0]      cfg_n_inv = '0;
   logic [7:0]      cfg_d_inv = '0;
   logic            clk_out;
   logic            running;

   frac_clk_div #(.NUM_SRC(NSRC), .HID_W(5), .MND_W(8), .HAS_MN(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .root_en(root_en), .src_en(src_en),
      .cfg_sel(cfg_sel), .cfg_hid(cfg_hid), .cfg_dual(cfg_dual), .cfg_m(cfg_m),
      .cfg_n_inv(cfg_n_inv), .cfg_d_inv(cfg_d_inv),
      .clk_out(clk_out), .running(running)
   );

   always #4 clk = ~clk;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string cur_tag  = "R1";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Source stimulus: 0 all on, 1 random sparse, 2 fixed pattern, 3 idle.
   int              src_mode = 0;
   logic [NSRC-1:0] src_fixed = '0;
   always @(negedge clk) begin
      case (src_mode)
         0: src_en <= '1;
         1: src_en <= NSRC'($urandom);
         2: src_en <= src_fixed;
         default: src_en <= '0;
      endcase
   end

   // Reference model built from the requirements.
   int         md_cnt, md_acc, p_i, n_i, d_i, s_i, sum_i;
   bit         md_out, md_run, fr, tk, lvl, endp, wrp, bnd, dif;
   logic [2:0] ms_sel;
   logic [4:0] ms_hid;
   logic       ms_dual;
   logic [7:0] ms_m, ms_ninv, ms_dinv, tmp8;

   task automatic model_load();
      ms_sel = cfg_sel; ms_hid = cfg_hid; ms_dual = cfg_dual;
      ms_m = cfg_m; ms_ninv = cfg_n_inv; ms_dinv = cfg_d_inv;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         md_cnt = 0; md_acc = 0; md_out = 0; md_run = 0;
         ms_sel = '0; ms_hid = '0; ms_dual = 1'b0; ms_m = '0; ms_ninv = '0; ms_dinv = '0;
      end else begin
         p_i  = (ms_hid < 2) ? 2 : ms_hid + 1;
         tmp8 = ~ms_ninv; n_i = tmp8 + ms_m;
         tmp8 = ~ms_dinv; d_i = tmp8;
         fr   = ms_dual && (n_i != 0) && (ms_m != n_i);
         s_i  = (ms_sel < NSRC) ? ms_sel : 0;
         tk   = src_en[s_i] && root_en;
         lvl  = fr ? (2 * md_acc < d_i) : (2 * md_cnt < p_i);
         dif  = (cfg_sel != ms_sel) || (cfg_hid != ms_hid) || (cfg_dual != ms_dual) ||
                (cfg_m != ms_m) || (cfg_n_inv != ms_ninv) || (cfg_d_inv != ms_dinv);
         if (!root_en) begin
            md_cnt = 0; md_acc = 0; model_load();
         end else begin
            endp  = tk && (md_cnt == p_i - 1);
            sum_i = md_acc + ms_m;
            wrp   = sum_i >= n_i;
            bnd   = endp && (fr ? wrp : 1'b1);
            if (bnd && dif) begin
               md_cnt = 0; md_acc = 0; model_load();
            end else if (tk) begin
               md_cnt = endp ? 0 : md_cnt + 1;
               if (endp && fr) md_acc = wrp ? sum_i - n_i : sum_i;
            end
         end
         md_out = root_en && lvl;
         md_run = root_en;
      end
   end

   bit cmp_on = 1'b0;
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(clk_out == md_out, {cur_tag, " model clk_out"}, clk_out, md_out);
         chk(running == md_run, {cur_tag, " model running"}, running, md_run);
      end
   end

   task automatic set_cfg(input int sel, input int hid, input bit dual,
                          input int m, input int n, input int d);
      @(negedge clk); root_en = 1'b0;
      cfg_sel = 3'(sel); cfg_hid = 5'(hid); cfg_dual = dual;
      cfg_m = 8'(m); cfg_n_inv = ~8'(n - m); cfg_d_inv = ~8'(d);
      repeat (2) @(negedge clk);
      root_en = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic count_high(input int cycles, output int h);
      h = 0;
      repeat (cycles) begin
         @(negedge clk); #1;
         if (clk_out) h++;
      end
   endtask

   task automatic run_len(input bit val, output int len);
      len = 1;
      forever begin
         @(negedge clk); #1;
         if (clk_out == val) len++;
         else break;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   int h, len, first;
   initial begin
      void'($urandom(32'h1d2c3b4a));
      repeat (3) @(negedge clk);
      chk(clk_out == 1'b0, "R1 clk_out in reset", clk_out, 0);
      chk(running == 1'b0, "R1 running in reset", running, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;

      cur_tag = "R3";
      set_cfg(1, 0, 0, 0, 1, 1);
      count_high(50, h); chk(h == 25, "R3 hid 0 high count", h, 25);
      set_cfg(1, 9, 0, 0, 1, 1);
      count_high(100, h); chk(h == 50, "R3 hid 9 high count", h, 50);

      cur_tag = "R4";
      set_cfg(1, 4, 0, 0, 1, 1);
      count_high(50, h); chk(h == 30, "R4 period 5 high count", h, 30);
      set_cfg(4, 2, 0, 0, 1, 1);
      count_high(60, h); chk(h == 40, "R4 period 3 high count", h, 40);

      cur_tag = "R5";
      set_cfg(0, 0, 1, 1, 4, 4);
      count_high(80, h); chk(h == 40, "R5 M1 N4 D4", h, 40);
      set_cfg(0, 0, 1, 3, 8, 8);
      count_high(80, h); chk(h == 40, "R5 M3 N8 D8", h, 40);
      set_cfg(0, 0, 1, 1, 4, 2);
      count_high(80, h); chk(h == 20, "R5 M1 N4 D2", h, 20);

      cur_tag = "R6";
      set_cfg(0, 0, 0, 1, 4, 2);
      count_high(50, h); chk(h == 25, "R6 dual off bypass", h, 25);
      set_cfg(0, 0, 1, 4, 4, 2);
      count_high(50, h); chk(h == 25, "R6 M equal N bypass", h, 25);

      cur_tag = "R2";
      src_mode = 2; src_fixed = 5'b00001;
      set_cfg(7, 0, 0, 0, 1, 1);
      count_high(50, h); chk(h == 25, "R2 code 7 falls back", h, 25);
      set_cfg(3, 0, 0, 0, 1, 1);
      count_high(50, h); chk(h == 50, "R2 idle source 3", h, 50);
      src_fixed = 5'b00100;
      set_cfg(2, 0, 0, 0, 1, 1);
      count_high(50, h); chk(h == 25, "R2 source 2", h, 25);

      cur_tag = "R9";
      src_mode = 0;
      set_cfg(1, 6, 0, 0, 1, 1);
      repeat (3) @(negedge clk);
      src_mode = 3;
      repeat (2) @(negedge clk); #1;
      first = clk_out;
      count_high(20, h); chk(h == 20 * first, "R9 hold while idle", h, 20 * first);

      cur_tag = "R7";
      src_mode = 0;
      set_cfg(1, 8, 0, 0, 1, 1);
      begin
         int prev;
         prev = 1;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (prev == 0 && clk_out == 1'b1) break;
            prev = clk_out;
         end
      end
      cfg_hid = 5'd2;
      run_len(1'b1, len); chk(len == 5, "R7 old high run", len, 5);
      run_len(1'b0, len); chk(len == 4, "R7 old low run", len, 4);
      run_len(1'b1, len); chk(len == 2, "R7 new high run", len, 2);
      run_len(1'b0, len); chk(len == 1, "R7 new low run", len, 1);

      cur_tag = "R8";
      @(negedge clk); #1;
      chk(running == 1'b1, "R8 running while on", running, 1);
      root_en = 1'b0;
      @(negedge clk); #1;
      chk(clk_out == 1'b0, "R8 clk_out off", clk_out, 0);
      chk(running == 1'b0, "R8 running off", running, 0);
      root_en = 1'b1;
      @(negedge clk); #1;
      chk(running == 1'b1, "R8 running on again", running, 1);
      chk(clk_out == 1'b1, "R8 fresh start high", clk_out, 1);

      cur_tag = "R7";
      src_mode = 1;
      for (int it = 0; it < 40; it++) begin
         int n, m;
         @(negedge clk);
         n = 1 + ($urandom % 255);
         m = $urandom % (n + 1);
         cfg_sel  = 3'($urandom);
         cfg_hid  = 5'($urandom);
         cfg_dual = ($urandom % 4) != 0;
         cfg_m    = 8'(m);
         cfg_n_inv = ((it % 5) == 0) ? 8'($urandom) : ~8'(n - m);
         cfg_d_inv = ~8'($urandom % (n + 1));
         if ((it % 7) == 3) root_en = 1'b0;
         else root_en = 1'b1;
         if ((it % 3) == 0) src_mode = 0;
         else src_mode = 1;
         repeat (200) @(negedge clk);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule